// File: doc/BRIEF.md
# USB Device Interrupt Flag and Enable Register Pair

This block gathers the status events of a USB device serial interface engine into one byte of sticky flags, with a second byte of per-flag enables. The engine reports start-of-frame, stall, transaction-complete, bus-activity and bus-reset events as single-cycle pulses. An idle timer watches the bus line state and raises its own flag after a long quiet period. A masked error summary is formed from an error-flag vector and an error-enable vector. A combined interrupt request goes to the processor.

Firmware reads and writes both bytes through a plain register port. A flag is removed by writing a zero to its position, and writing a one forces it set, which lets firmware test its handlers without any bus traffic. Clearing the transaction flag emits a one-cycle pulse that steps the transaction status FIFO. A bus reset emits a one-cycle pulse that zeroes the device address register. While the engine is suspended, only bus activity can raise a flag.

Top module: `usb_irq_stat`

## Requirements
- R1: After reset both bytes read 0x00. Status bit positions are: 6 start-of-frame, 5 stall, 4 idle, 3 transaction, 2 activity, 1 error summary, 0 bus reset. Bit 7 of either byte always reads 0.
- R2: An accepted hardware event pulse sets its flag, and the flag is visible on the clock after the pulse. The flag then stays 1 until firmware writes 0 at that position.
- R3: A status write (reg_sel=0) loads bits 6, 5, 4, 3, 2 and 0 from reg_wdata. A 1 sets the flag and a 0 clears it. Bits 7 and 1 of the written data are ignored.
- R4: Status bit 1 cannot be written. It reads 1 exactly when some bit of err_flags is 1 with the same bit of err_en also 1.
- R5: The idle flag is set once line_idle has been sampled high on IDLE_MS*CLK_KHZ consecutive unsuspended clocks. A low sample restarts the count, and suspended clocks neither add to the count nor reset it.
- R6: While suspend is 1, event pulses other than activity, and the idle timer, set no flag. Activity still sets bit 2.
- R7: When a firmware write turns the transaction flag from 1 to 0, fifo_adv is 1 for the following clock only. This happens only if the latest hardware transaction event came with trn_tok_ok=1. A firmware-forced transaction flag never advances the FIFO.
- R8: An accepted bus-reset pulse sets bit 0 and drives addr_clr high for exactly the clock in which the flag first reads 1.
- R9: An enable write (reg_sel=1) stores reg_wdata bits 6..0. irq is 1 exactly when some status bit, including the error summary, is 1 with its enable bit also 1.
- R10: If a hardware set and a firmware clear reach the same flag in the same clock, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_evt | input | 1 | Start-of-frame received pulse |
| stall_evt | input | 1 | Stall handshake sent pulse |
| trn_evt | input | 1 | Transaction complete pulse |
| trn_tok_ok | input | 1 | Qualifies trn_evt: token was IN, OUT or SETUP |
| actv_evt | input | 1 | Bus activity pulse |
| busrst_evt | input | 1 | Valid bus reset pulse |
| line_idle | input | 1 | Bus line state is idle |
| err_flags | input | ERR_W | Error condition flags |
| err_en | input | ERR_W | Error enable mask |
| suspend | input | 1 | Engine suspended (unclocked) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected byte |
| irq | output | 1 | Combined interrupt request |
| addr_clr | output | 1 | Pulse to zero the device address |
| fifo_adv | output | 1 | Pulse to advance the transaction status FIFO |

## Verification
The reference model is driven with isolated single events, with firmware writes that force all flags to one and then to zero, and with a hardware pulse landing in the same clock as a write that clears it. The last case separates "hardware wins" from "last writer wins". Idle runs one clock short of the threshold, runs broken by a single busy sample, and runs paused by suspend show whether the timer restarts or freezes at the right moments. Transaction clears with the token qualifier high, low, and after a firmware-forced set separate a correct FIFO step from a spurious one. Sweeps of err_en against err_flags and of the enable byte show that the error summary and irq follow the masks and that neither can be set by a write.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int B_SOF   = 6;
  localparam int B_STALL = 5;
  localparam int B_IDLE  = 4;
  localparam int B_TRN   = 3;
  localparam int B_ACTV  = 2;
  localparam int B_ERR   = 1;
  localparam int B_RST   = 0;
  localparam logic [7:0] WR_MASK = 8'h7D;
  localparam logic [7:0] EN_MASK = 8'h7F;

  // next stored flag byte: firmware load first, hardware set on top
  function automatic logic [7:0] stat_apply(input logic [7:0] cur,
                                            input logic [7:0] wdata,
                                            input logic       wr,
                                            input logic [7:0] hw);
    logic [7:0] v;
    v = wr ? ((cur & ~WR_MASK) | (wdata & WR_MASK)) : cur;
    return (v | hw) & WR_MASK;
  endfunction
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE_CYCLES = 144000,
  localparam int CW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_idle,
  input  logic suspend,
  output logic idle_hit
);
  logic [CW-1:0] cnt_q;

  assign idle_hit = line_idle && !suspend && (cnt_q == CW'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!line_idle) begin
      cnt_q <= '0;
    end else if (!suspend && cnt_q != CW'(IDLE_CYCLES)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_evt_gate.sv
module usb_evt_gate
  import usb_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       suspend,
  input  logic       sof_evt,
  input  logic       stall_evt,
  input  logic       trn_evt,
  input  logic       actv_evt,
  input  logic       busrst_evt,
  input  logic       idle_hit,
  output logic [7:0] hw_set,
  output logic       addr_clr
);
  logic run;
  assign run = !suspend;

  always_comb begin
    hw_set          = '0;
    hw_set[B_SOF]   = run && sof_evt;
    hw_set[B_STALL] = run && stall_evt;
    hw_set[B_IDLE]  = idle_hit;
    hw_set[B_TRN]   = run && trn_evt;
    hw_set[B_ACTV]  = actv_evt;
    hw_set[B_RST]   = run && busrst_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_clr <= 1'b0;
    else        addr_clr <= hw_set[B_RST];
  end
endmodule

// File: rtl/usb_stat_flags.sv
module usb_stat_flags
  import usb_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] hw_set,
  input  logic       sw_wr,
  input  logic [7:0] sw_wdata,
  input  logic       trn_tok_ok,
  output logic [7:0] stat_q,
  output logic       fifo_adv
);
  logic [7:0] stat_nxt;
  logic       tok_q;
  logic       trn_fall;
  logic       trn_sw_rise;

  assign stat_nxt    = stat_apply(stat_q, sw_wdata, sw_wr, hw_set);
  assign trn_fall    = stat_q[B_TRN] && !stat_nxt[B_TRN];
  assign trn_sw_rise = sw_wr && sw_wdata[B_TRN] && !stat_q[B_TRN] && !hw_set[B_TRN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      tok_q    <= 1'b0;
      fifo_adv <= 1'b0;
    end else begin
      stat_q   <= stat_nxt;
      fifo_adv <= trn_fall && tok_q;
      if (hw_set[B_TRN])   tok_q <= trn_tok_ok;
      else if (trn_sw_rise) tok_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_en.sv
module usb_irq_en
  import usb_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  input  logic [7:0] stat_view,
  output logic [7:0] en_q,
  output logic       irq
);
  assign irq = |(stat_view & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata & EN_MASK;
  end
endmodule

// File: rtl/usb_irq_stat.sv
module usb_irq_stat
  import usb_irq_pkg::*;
#(
  parameter int CLK_KHZ = 48000,
  parameter int IDLE_MS = 3,
  parameter int ERR_W   = 8,
  localparam int IDLE_CYCLES = CLK_KHZ * IDLE_MS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_evt,
  input  logic             stall_evt,
  input  logic             trn_evt,
  input  logic             trn_tok_ok,
  input  logic             actv_evt,
  input  logic             busrst_evt,
  input  logic             line_idle,
  input  logic [ERR_W-1:0] err_flags,
  input  logic [ERR_W-1:0] err_en,
  input  logic             suspend,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic             addr_clr,
  output logic             fifo_adv
);
  logic       idle_hit;
  logic [7:0] hw_set;
  logic [7:0] stat_q;
  logic [7:0] stat_view;
  logic [7:0] en_q;
  logic       err_sum;
  logic       stat_wr;
  logic       en_wr;

  assign stat_wr   = reg_wr && !reg_sel;
  assign en_wr     = reg_wr && reg_sel;
  assign err_sum   = |(err_flags & err_en);
  assign stat_view = stat_q | (8'(err_sum) << B_ERR);
  assign reg_rdata = reg_sel ? en_q : stat_view;

  usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .line_idle(line_idle),
    .suspend(suspend), .idle_hit(idle_hit)
  );

  usb_evt_gate u_gate (
    .clk(clk), .rst_n(rst_n), .suspend(suspend),
    .sof_evt(sof_evt), .stall_evt(stall_evt), .trn_evt(trn_evt),
    .actv_evt(actv_evt), .busrst_evt(busrst_evt), .idle_hit(idle_hit),
    .hw_set(hw_set), .addr_clr(addr_clr)
  );

  usb_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_wr(stat_wr),
    .sw_wdata(reg_wdata), .trn_tok_ok(trn_tok_ok),
    .stat_q(stat_q), .fifo_adv(fifo_adv)
  );

  usb_irq_en u_en (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(reg_wdata),
    .stat_view(stat_view), .en_q(en_q), .irq(irq)
  );
endmodule

// File: rtl/usb_irq_stat_chk.sv
module usb_irq_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       suspend,
  input logic       stat_wr,
  input logic       reg_sel,
  input logic [7:0] reg_rdata,
  input logic [7:0] stat_q,
  input logic [7:0] hw_set,
  input logic       err_sum,
  input logic       addr_clr,
  input logic       fifo_adv
);
  // R2: a set flag holds while firmware does not write the status byte
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[6] && !stat_wr) |=> stat_q[6]);
  // R1: bit 7 reads as zero in both bytes
  a_r1_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0);
  // R4: summary bit on the read port follows the masked error inputs
  a_r4_err_view: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[1] == err_sum));
  // R6: in suspend without writes, only the activity flag may change
  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !stat_wr) |=> ((stat_q & 8'h79) == ($past(stat_q) & 8'h79)));
  // R7: a FIFO step follows a fall of the transaction flag
  a_r7_fifo_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_adv |-> (!stat_q[3] && $past(stat_q[3])));
  // R8: address clear coincides with a set reset flag
  a_r8_addr_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |-> stat_q[0]);
  // R10: a hardware set always lands, whatever firmware writes
  a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set[3] |=> stat_q[3]);
endmodule

bind usb_irq_stat usb_irq_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .stat_wr(stat_wr),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .stat_q(stat_q),
  .hw_set(hw_set), .err_sum(err_sum), .addr_clr(addr_clr), .fifo_adv(fifo_adv)
);

// File: tb/usb_irq_stat_bench.sv
`timescale 1ns/1ps
module usb_irq_stat_bench;
  localparam int KHZ  = 10;
  localparam int IDLE = KHZ * 3;
  localparam int EW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_evt = 0, stall_evt = 0, trn_evt = 0, trn_tok_ok = 0;
  logic actv_evt = 0, busrst_evt = 0, line_idle = 0, suspend = 0;
  logic [EW-1:0] err_flags = '0, err_en = '0;
  logic reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, addr_clr, fifo_adv;

  always #2.5 clk = ~clk;

  usb_irq_stat #(.CLK_KHZ(KHZ), .IDLE_MS(3), .ERR_W(EW)) u_usb_irq_stat (
    .clk(clk), .rst_n(rst_n), .sof_evt(sof_evt), .stall_evt(stall_evt),
    .trn_evt(trn_evt), .trn_tok_ok(trn_tok_ok), .actv_evt(actv_evt),
    .busrst_evt(busrst_evt), .line_idle(line_idle), .err_flags(err_flags),
    .err_en(err_en), .suspend(suspend), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .addr_clr(addr_clr), .fifo_adv(fifo_adv)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state: individual booleans per flag
  bit f_sof, f_stall, f_idle, f_trn, f_actv, f_rst;
  bit [6:0] m_en;
  int idle_run;
  bit tok;
  bit e_addr, e_fifo;

  function automatic bit [7:0] m_view();
    bit e;
    e = (err_flags & err_en) != 0;
    return {1'b0, f_sof, f_stall, f_idle, f_trn, f_actv, e, f_rst};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // advance one clock: predict, clock, compare at the falling edge
  task automatic cyc(input string tag);
    bit run, was_trn, n_trn;
    bit h_sof, h_stall, h_idle, h_trn, h_actv, h_rst;
    run = !suspend;
    if (!line_idle) idle_run = 0;
    else if (run) idle_run++;
    h_idle  = run && line_idle && idle_run == IDLE;
    h_sof   = run && sof_evt;
    h_stall = run && stall_evt;
    h_trn   = run && trn_evt;
    h_actv  = actv_evt;
    h_rst   = run && busrst_evt;
    was_trn = f_trn;
    if (reg_wr && !reg_sel) begin
      f_sof = reg_wdata[6]; f_stall = reg_wdata[5]; f_idle = reg_wdata[4];
      f_trn = reg_wdata[3]; f_actv = reg_wdata[2]; f_rst = reg_wdata[0];
    end
    if (reg_wr && reg_sel) m_en = reg_wdata[6:0];
    n_trn = f_trn | h_trn;
    e_fifo = was_trn && !n_trn && tok;
    if (h_trn) tok = trn_tok_ok;
    else if (!was_trn && n_trn) tok = 0;
    f_sof |= h_sof; f_stall |= h_stall; f_idle |= h_idle;
    f_trn = n_trn;  f_actv |= h_actv;   f_rst |= h_rst;
    e_addr = h_rst;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rdata", reg_rdata, reg_sel ? {1'b0, m_en} : m_view());
    chk(tag, "irq", irq, (m_view() & {1'b0, m_en}) != 0);
    chk(tag, "addr_clr", addr_clr, e_addr);
    chk(tag, "fifo_adv", fifo_adv, e_fifo);
  endtask

  task automatic idle_cyc(input string tag);
    sof_evt = 0; stall_evt = 0; trn_evt = 0; actv_evt = 0; busrst_evt = 0; reg_wr = 0;
    cyc(tag);
  endtask

  task automatic wr(input string tag, input bit sel, input bit [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    cyc(tag);
    reg_wr = 0; reg_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on both bytes
    chk("R1", "status after reset", reg_rdata, 0);
    reg_sel = 1; #0.1;
    chk("R1", "enable after reset", reg_rdata, 0);
    reg_sel = 0;
    idle_cyc("R1");

    // R2: single events, held across idle clocks
    sof_evt = 1; cyc("R2"); idle_cyc("R2"); idle_cyc("R2");
    stall_evt = 1; cyc("R2"); idle_cyc("R2");
    actv_evt = 1; cyc("R2"); idle_cyc("R2");
    // R3: clear all, force all, bits 7 and 1 ignored
    wr("R3", 0, 8'h00); idle_cyc("R3");
    wr("R3", 0, 8'hFF); idle_cyc("R3");
    wr("R3", 0, 8'h02); idle_cyc("R3");
    wr("R3", 0, 8'h00);
    // R10: hardware set against clearing write
    wr("R10", 0, 8'h7D);
    sof_evt = 1; trn_evt = 1; reg_wr = 1; reg_wdata = 8'h00; cyc("R10");
    idle_cyc("R10");
    wr("R3", 0, 8'h00);

    // R9: enable byte and irq gating
    wr("R9", 1, 8'hFF); idle_cyc("R9");
    wr("R9", 1, 8'h40);
    stall_evt = 1; cyc("R9"); idle_cyc("R9");
    sof_evt = 1; cyc("R9"); idle_cyc("R9");
    wr("R9", 1, 8'h20); idle_cyc("R9");
    wr("R3", 0, 8'h00);
    // R4: error summary masks, not writable
    wr("R4", 1, 8'h02);
    for (int i = 0; i < 16; i++) begin
      err_flags = i[3:0]; err_en = 4'(i * 7);
      idle_cyc("R4");
    end
    err_flags = 4'h4; err_en = 4'h4; wr("R4", 0, 8'h00); idle_cyc("R4");
    err_flags = 0; err_en = 0; wr("R4", 0, 8'h02); idle_cyc("R4");
    wr("R9", 1, 8'h7F);

    // R8: bus reset
    busrst_evt = 1; cyc("R8"); idle_cyc("R8"); idle_cyc("R8");
    wr("R8", 0, 8'h00);

    // R7: transaction clears with and without the token qualifier
    trn_evt = 1; trn_tok_ok = 1; cyc("R7"); trn_tok_ok = 0; idle_cyc("R7");
    wr("R7", 0, 8'h00); idle_cyc("R7"); idle_cyc("R7");
    trn_evt = 1; trn_tok_ok = 0; cyc("R7");
    wr("R7", 0, 8'h00); idle_cyc("R7");
    trn_evt = 1; trn_tok_ok = 1; cyc("R7"); trn_tok_ok = 0;
    wr("R7", 0, 8'h00); idle_cyc("R7");
    wr("R7", 0, 8'h08); wr("R7", 0, 8'h00); idle_cyc("R7");

    // R5: idle run short by one, broken, then complete
    line_idle = 1;
    for (int i = 0; i < IDLE - 1; i++) idle_cyc("R5");
    line_idle = 0; idle_cyc("R5");
    line_idle = 1;
    for (int i = 0; i < IDLE + 4; i++) idle_cyc("R5");
    wr("R5", 0, 8'h00);
    for (int i = 0; i < 6; i++) idle_cyc("R5");

    // R6: suspend freezes the timer and masks events except activity
    line_idle = 0; idle_cyc("R6"); line_idle = 1;
    for (int i = 0; i < IDLE - 2; i++) idle_cyc("R6");
    suspend = 1;
    for (int i = 0; i < 5; i++) idle_cyc("R6");
    sof_evt = 1; stall_evt = 1; trn_evt = 1; busrst_evt = 1; cyc("R6");
    idle_cyc("R6");
    actv_evt = 1; cyc("R6"); idle_cyc("R6");
    suspend = 0;
    for (int i = 0; i < 4; i++) idle_cyc("R5");
    line_idle = 0; idle_cyc("R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule